// File: doc/BRIEF.md
# Page-Bounded Scatter Descriptor Builder

This block turns a single transfer request (start byte address, byte count and direction) into a table of physical-region descriptors. Each descriptor names a base address and a segment length, and no segment ever runs across a page boundary. The first segment covers only what is left of the start address's page. Every following segment is a whole page, or whatever is left if that is less. The last descriptor written carries an end-of-table flag. Addresses are used untranslated.

Descriptors leave one per cycle over a valid/ready write port, at table indices 0, 1, 2 and so on. A downstream descriptor memory of fixed depth sits behind that port. When the request has been fully described, or has been refused, the block raises a status word and holds it until the status is acknowledged. Three kinds of request are refused before any write takes place: an odd address or count, an empty count, and a request that would need more descriptors than the table holds. A request presented while the block is working is dropped.

Top module: `sgd_builder`

## Requirements
- R1: A request whose start address or byte count is odd ends with status code 1 and causes no descriptor write. This check takes priority over R2.
- R2: A request with an even address and a zero byte count ends with status code 2 and causes no descriptor write.
- R3: The first descriptor's base equals the start address. Its length is the smaller of the byte count and (PAGE_BYTES minus the start address modulo PAGE_BYTES).
- R4: Each later descriptor's base is the previous base plus the previous length. Its length is the smaller of the bytes still uncovered and PAGE_BYTES.
- R5: In the 32-bit count word, bits 15:0 hold the low 16 bits of the segment length and bits 30:16 are zero.
- R6: Bit 31 of the count word is set on the final descriptor of an accepted request and is clear on every other descriptor.
- R7: A request that needs more than TABLE_DEPTH descriptors ends with status code 3 and causes no descriptor write. A request that needs exactly TABLE_DEPTH descriptors is accepted.
- R8: Descriptor writes use indices 0, 1, 2 and so on. Each write carries the request's direction bit. A write and a pending status both hold steady while they are not accepted. Status code 0 (success) appears only after the final write has been accepted.
- R9: A request presented while busy is high is ignored, and it produces no descriptors and no status.
- R10: After reset the block is idle: busy, wr_valid and stat_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | One-cycle request strobe, taken only while idle |
| req_addr | input | ADDR_W | Start byte address |
| req_count | input | CNT_W | Byte count |
| req_dir | input | 1 | Transfer direction, copied onto every write |
| busy | output | 1 | High from request acceptance until status acknowledge |
| wr_valid | output | 1 | A descriptor is offered |
| wr_ready | input | 1 | The descriptor memory accepts the offered descriptor |
| wr_index | output | IDX_W | Table index of the offered descriptor |
| wr_base | output | ADDR_W | Segment base address |
| wr_cnt_word | output | 32 | Count word: bit 31 end-of-table, bits 15:0 length |
| wr_dir | output | 1 | Direction of the request |
| stat_valid | output | 1 | Status is offered |
| stat_ready | input | 1 | Status acknowledge |
| stat_code | output | 2 | 0 success, 1 odd, 2 empty, 3 too many segments |

## Verification
The bench uses start addresses that sit at the very start of a page, in the middle of a page, and two bytes short of a page end. A design that failed to cut the first segment at the page end would emit a segment crossing the boundary, and one that measured later segments from the start address would shift every base. Requests needing exactly TABLE_DEPTH descriptors and one more than that are both sent. This exposes an off-by-one in the capacity test, which would either refuse a legal table or write past it. Odd, empty and odd-plus-empty requests confirm that refusals write nothing and report the right code. A request strobed mid-transfer while writes are stalled would, if not ignored, show up as extra writes or an extra status.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_ODD     = 2'd1,
    ST_EMPTY   = 2'd2,
    ST_TOOMANY = 2'd3
  } sgd_status_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_EMIT = 2'd1,
    FSM_STAT = 2'd2
  } sgd_fsm_e;

  localparam int unsigned EOT_BIT = 31;
endpackage

// File: rtl/sgd_req_check.sv
module sgd_req_check
  import sgd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned TABLE_DEPTH = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  output sgd_status_e       verdict
);
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
  localparam int unsigned SUM_W  = CNT_W + 2;

  logic [SUM_W-1:0] span_end;
  logic [SUM_W-1:0] seg_need;

  // pages touched = ceil((offset in page + count) / page)
  always_comb begin
    span_end = SUM_W'(addr[PAGE_W-1:0]) + SUM_W'(count);
    seg_need = (span_end + SUM_W'(PAGE_BYTES - 1)) >> PAGE_W;
    if (addr[0] || count[0])
      verdict = ST_ODD;
    else if (count == '0)
      verdict = ST_EMPTY;
    else if (seg_need > SUM_W'(TABLE_DEPTH))
      verdict = ST_TOOMANY;
    else
      verdict = ST_OK;
  end
endmodule

// File: rtl/sgd_seg_calc.sv
module sgd_seg_calc
  import sgd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic [ADDR_W-1:0]              cur_addr,
  input  logic [CNT_W-1:0]               remain,
  output logic [$clog2(PAGE_BYTES):0]    seg_len,
  output logic                           seg_last,
  output logic [31:0]                    cnt_word
);
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
  localparam int unsigned CMP_W  = CNT_W + 1;

  logic [PAGE_W:0]  room;
  logic [31:0]      len_wide;

  always_comb begin
    room     = (PAGE_W+1)'(PAGE_BYTES) - (PAGE_W+1)'(cur_addr[PAGE_W-1:0]);
    seg_last = CMP_W'(remain) <= CMP_W'(room);
    seg_len  = seg_last ? (PAGE_W+1)'(remain) : room;
    len_wide = 32'(seg_len);
    cnt_word = {seg_last, 15'd0, len_wide[15:0]};
  end
endmodule

// File: rtl/sgd_builder.sv
module sgd_builder
  import sgd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned PAGE_BYTES  = 4096,
  parameter int unsigned TABLE_DEPTH = 8,
  parameter int unsigned IDX_W       = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_dir,
  output logic              busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IDX_W-1:0]  wr_index,
  output logic [ADDR_W-1:0] wr_base,
  output logic [31:0]       wr_cnt_word,
  output logic              wr_dir,
  output logic              stat_valid,
  input  logic              stat_ready,
  output logic [1:0]        stat_code
);
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  sgd_fsm_e          state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              dir_q, dir_d;
  sgd_status_e       code_q, code_d;
  logic              load_en;

  sgd_status_e       verdict;
  logic [PAGE_W:0]   seg_len;
  logic              seg_last;
  logic [31:0]       cnt_word;

  sgd_req_check #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES), .TABLE_DEPTH(TABLE_DEPTH)
  ) u_check (
    .addr(req_addr), .count(req_count), .verdict(verdict)
  );

  sgd_seg_calc #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_seg (
    .cur_addr(addr_q), .remain(rem_q), .seg_len(seg_len),
    .seg_last(seg_last), .cnt_word(cnt_word)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    dir_d   = dir_q;
    code_d  = code_q;
    load_en = 1'b0;
    unique case (state_q)
      FSM_IDLE: begin
        if (req_valid) begin
          load_en = 1'b1;
          addr_d  = req_addr;
          rem_d   = req_count;
          idx_d   = '0;
          dir_d   = req_dir;
          code_d  = verdict;
          state_d = (verdict == ST_OK) ? FSM_EMIT : FSM_STAT;
        end
      end
      FSM_EMIT: begin
        if (wr_ready) begin
          load_en = 1'b1;
          addr_d  = addr_q + ADDR_W'(seg_len);
          rem_d   = rem_q - CNT_W'(seg_len);
          idx_d   = idx_q + 1'b1;
          if (seg_last) state_d = FSM_STAT;
        end
      end
      FSM_STAT: begin
        if (stat_ready) begin
          load_en = 1'b1;
          state_d = FSM_IDLE;
        end
      end
      default: begin
        load_en = 1'b1;
        state_d = FSM_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= FSM_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      dir_q   <= 1'b0;
      code_q  <= ST_OK;
    end else if (load_en) begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      idx_q   <= idx_d;
      dir_q   <= dir_d;
      code_q  <= code_d;
    end
  end

  always_comb begin
    busy        = state_q != FSM_IDLE;
    wr_valid    = state_q == FSM_EMIT;
    wr_index    = idx_q;
    wr_base     = addr_q;
    wr_cnt_word = cnt_word;
    wr_dir      = dir_q;
    stat_valid  = state_q == FSM_STAT;
    stat_code   = code_q;
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_base) && $stable(wr_cnt_word) && $stable(wr_index)); // R8
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    stat_valid && !stat_ready |=> stat_valid && $stable(stat_code)); // R8
  AST_EOT_ENDS: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_valid && wr_ready && wr_cnt_word[EOT_BIT] |=> !wr_valid && stat_valid && stat_code == 2'd0); // R6
  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_valid |-> (32'(wr_base[PAGE_W-1:0]) + 32'(seg_len)) <= 32'(PAGE_BYTES)); // R4
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy && req_valid && verdict != ST_OK |=> !wr_valid && stat_valid); // R1
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_ns)
    stat_valid && !stat_ready |=> !wr_valid); // R9
endmodule

// File: tb/sgd_builder_tb.sv
module sgd_builder_tb;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 20;
  localparam int unsigned PAGE   = 4096;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned IDX_W  = 3;

  typedef struct {
    int unsigned idx;
    int unsigned base;
    int unsigned word;
    bit          dir;
    string       tag;
  } wr_exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [CNT_W-1:0]  req_count;
  logic req_dir;
  logic busy, wr_valid, wr_ready, wr_dir, stat_valid, stat_ready;
  logic [IDX_W-1:0] wr_index;
  logic [ADDR_W-1:0] wr_base;
  logic [31:0] wr_cnt_word;
  logic [1:0] stat_code;

  int checks = 0;
  int fails  = 0;
  int stat_seen = 0;
  bit hold_ready = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  wr_exp_t wq[$];
  int unsigned sq[$];
  string stag[$];

  always #5 clk = ~clk;

  sgd_builder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_count(req_count), .req_dir(req_dir), .busy(busy), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_index(wr_index), .wr_base(wr_base),
    .wr_cnt_word(wr_cnt_word), .wr_dir(wr_dir), .stat_valid(stat_valid),
    .stat_ready(stat_ready), .stat_code(stat_code)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ready generation, one step after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready   <= hold_ready ? 1'b0 : (lfsr[0] | lfsr[3]);
    stat_ready <= lfsr[1] | lfsr[6];
  end

  // monitor: compare at falling edge
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (wq.size() == 0) begin
        check(0, "R9 unexpected descriptor write", longint'(wr_base), 0);
      end else begin
        wr_exp_t e;
        e = wq.pop_front();
        check(wr_index == e.idx[IDX_W-1:0], {e.tag, " R8 index"}, wr_index, e.idx);
        check(wr_base == e.base, {e.tag, " base"}, wr_base, e.base);
        check(wr_cnt_word == e.word, {e.tag, " R5 R6 count word"}, wr_cnt_word, e.word);
        check(wr_dir == e.dir, {e.tag, " R8 direction"}, wr_dir, e.dir);
      end
    end
    if (rst_n && stat_valid && stat_ready) begin
      if (sq.size() == 0) begin
        check(0, "R9 unexpected status", stat_code, 0);
      end else begin
        int unsigned ec;
        string t;
        ec = sq.pop_front();
        t = stag.pop_front();
        check(stat_code == ec[1:0], {t, " status code"}, stat_code, ec);
        check(wq.size() == 0, "R8 status before final write", wq.size(), 0);
      end
      stat_seen++;
    end
  end

  // driver: compute expectations, then strobe the request
  task automatic run_req(input longint addr, input longint cnt, input bit dir, input string tag);
    int target;
    if ((addr % 2) != 0 || (cnt % 2) != 0) begin
      sq.push_back(1); stag.push_back({tag, " R1"});
    end else if (cnt == 0) begin
      sq.push_back(2); stag.push_back({tag, " R2"});
    end else begin
      longint a = addr, r = cnt, l;
      wr_exp_t tmp[$];
      int n = 0;
      while (r > 0) begin
        longint room = PAGE - (a % PAGE);
        l = (r < room) ? r : room;
        tmp.push_back('{idx: n, base: int'(a), word: (int'(l) & 32'hFFFF) | ((r == l) ? 32'h8000_0000 : 0),
                        dir: dir, tag: (n == 0) ? {tag, " R3"} : {tag, " R4"}});
        a += l; r -= l; n++;
      end
      if (n > DEPTH) begin
        sq.push_back(3); stag.push_back({tag, " R7"});
      end else begin
        foreach (tmp[i]) wq.push_back(tmp[i]);
        sq.push_back(0); stag.push_back({tag, " R7 R8"});
      end
    end
    target = stat_seen + 1;
    @(posedge clk); #2;
    req_valid = 1'b1; req_addr = addr[ADDR_W-1:0]; req_count = cnt[CNT_W-1:0]; req_dir = dir;
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (stat_seen < target) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int target;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_count = '0; req_dir = 1'b0;
    wr_ready = 1'b0; stat_ready = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!busy && !wr_valid && !stat_valid, "R10 reset idle", {busy, wr_valid, stat_valid}, 0);

    run_req(32'h0000_1000, 20'h100, 1'b0, "page start single");
    run_req(32'h0000_1F00, 20'h300, 1'b1, "mid page split");
    run_req(32'h0000_0FFE, 2*PAGE + 10, 1'b0, "two bytes short");
    run_req(32'h0000_2001, 20'h40, 1'b0, "odd addr");
    run_req(32'h0000_2000, 20'h41, 1'b1, "odd count");
    run_req(32'h0000_2000, 20'h0, 1'b0, "empty");
    run_req(32'h0000_2003, 20'h0, 1'b0, "odd and empty");
    run_req(32'h0000_3000, DEPTH*PAGE, 1'b1, "full table aligned");
    run_req(32'h0000_3010, DEPTH*PAGE - 16, 1'b0, "full table offset");
    run_req(32'h0000_3010, DEPTH*PAGE, 1'b0, "one over capacity");
    run_req(32'h0000_0000, (DEPTH+3)*PAGE, 1'b1, "far over capacity");
    run_req(32'hFFFF_F800, 20'h1000, 1'b1, "address wrap");

    // R9: strobe a second request while the first is stalled
    hold_ready = 1'b1;
    wq.push_back('{idx: 0, base: 32'h5F80, word: 32'h80, dir: 1'b0, tag: "busy R3"});
    wq.push_back('{idx: 1, base: 32'h6000, word: 32'h8000_0080, dir: 1'b0, tag: "busy R4"});
    sq.push_back(0); stag.push_back("busy R9");
    target = stat_seen + 1;
    @(posedge clk); #2;
    req_valid = 1'b1; req_addr = 32'h5F80; req_count = 20'h100; req_dir = 1'b0;
    @(posedge clk); #2;
    req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check(busy == 1'b1, "R9 busy during stall", busy, 1);
    req_valid = 1'b1; req_addr = 32'h7000; req_count = 20'h20; req_dir = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    hold_ready = 1'b0;
    while (stat_seen < target) @(posedge clk);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(!busy && !wr_valid && !stat_valid, "R9 idle after ignored request", {busy, wr_valid, stat_valid}, 0);
    check(wq.size() == 0 && sq.size() == 0, "R8 all expectations consumed", wq.size() + sq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule